// File: doc/BRIEF.md
# Interrupt Destination and Delivery Resolver

This block takes one interrupt request from a redirection stage and decides which processors receive it. The request carries a source pin number, a vector, a destination byte, a destination-mode flag (physical or logical), a delivery mode and a trigger flag. Every processor supplies four things through a static sideband: a present flag, an 8-bit physical ID, an 8-bit logical ID and a 4-bit priority. From these the block builds a target bitmask of up to `NCPU` processors.

The block then dispatches the request according to its delivery mode. Fixed mode sends a one-cycle injection strobe, carrying the vector and trigger flag, to every target in turn. NMI mode sends a non-maskable strobe to every target in turn. Lowest-priority mode picks exactly one target. Each request ends with a one-cycle completion pulse that reports whether any strobe was issued.

The controller is a five-state machine. In `S_IDLE` it accepts a request (transition *accept*). `S_RESOLVE` computes the target mask. From there it goes to `S_DONE` on an empty mask or an unsupported mode (*drop*), to `S_PICK` for lowest priority (*arbitrate*), or to `S_WALK` for fixed or NMI (*broadcast*). `S_PICK` narrows the mask to a single processor and moves to `S_WALK` (*narrow*). `S_WALK` issues one strobe per cycle and stays there while targets remain (*next*). After the last target it moves to `S_DONE` (*drain*). `S_DONE` pulses the result and returns to `S_IDLE` (*retire*).

Top module: `irq_dest_resolver`

## Requirements
- R1: After reset, `req_ready` is 1 and `irq_strobe`, `nmi_strobe` and `done_valid` are all 0.
- R2: In physical mode (`req_logical`=0), destination 0xFF targets every processor whose `cpu_present` bit is 1.
- R3: In physical mode with any destination other than 0xFF, the only target is the lowest-indexed present processor whose physical ID equals the destination. No other processor is targeted, even if its ID also matches.
- R4: In logical mode (`req_logical`=1), destination 0 targets nobody. Any other destination targets every present processor whose logical ID, ANDed bitwise with the destination, is nonzero.
- R5: An empty target mask produces no strobe. It produces a completion pulse with `done_delivered`=0.
- R6: Fixed mode (`req_mode`=3'b000) issues one `irq_strobe` per cycle, one-hot, to each target in ascending index order. Each strobe carries the request's vector on `irq_vector` and its trigger flag on `irq_level`.
- R7: NMI mode (`req_mode`=3'b100) issues one-hot `nmi_strobe` pulses to each target in ascending order. `irq_strobe` stays 0.
- R8: Lowest-priority mode (`req_mode`=3'b001) issues exactly one `irq_strobe`. It goes to the target with the smallest priority value, and ties go to the lowest index.
- R9: A request from pin 0 with a non-empty target mask, in fixed or lowest-priority mode, produces exactly one `irq_strobe`, and it goes to processor 0.
- R10: Any other `req_mode` value produces no strobe and a completion pulse with `done_delivered`=0.
- R11: `req_ready` is 0 from acceptance until the cycle after the completion pulse, and requests presented during that time are ignored. The completion pulse lasts one cycle. It has `done_delivered`=1 after at least one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_pin | input | PIN_W | Source pin number |
| req_vector | input | VEC_W | Interrupt vector |
| req_dest | input | ID_W | Destination byte |
| req_logical | input | 1 | 1 selects logical destination mode |
| req_mode | input | 3 | Delivery mode: 000 fixed, 001 lowest priority, 100 NMI |
| req_level | input | 1 | Trigger flag forwarded with injections |
| cpu_present | input | NCPU | Processor present flags |
| cpu_phys_id | input | NCPU*ID_W | Packed physical IDs, processor i at bits [i*ID_W +: ID_W] |
| cpu_logic_id | input | NCPU*ID_W | Packed logical IDs |
| cpu_prio | input | NCPU*PRIO_W | Packed priorities, smaller wins |
| irq_strobe | output | NCPU | One-hot vectored injection strobe |
| irq_vector | output | VEC_W | Vector accompanying `irq_strobe` |
| irq_level | output | 1 | Trigger flag accompanying `irq_strobe` |
| nmi_strobe | output | NCPU | One-hot non-maskable strobe |
| done_valid | output | 1 | One-cycle completion pulse |
| done_delivered | output | 1 | At least one strobe was issued |

## Verification
The bench builds the block with `NCPU`=6 and the default 8-bit IDs. Six processors are enough to leave one of them absent, give two processors the same physical ID, and give two processors the same priority. That covers the absent-processor filter, the first-match rule in physical mode and the lowest-index tie-break. With a small mask, every strobe sequence stays short enough to check whole against the scoreboard, including broadcast, logical overlap, pin-0 steering and dropped modes.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    localparam logic [2:0] MODE_FIXED  = 3'b000;
    localparam logic [2:0] MODE_LOWEST = 3'b001;
    localparam logic [2:0] MODE_NMI    = 3'b100;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_RESOLVE = 3'd1,
        S_PICK    = 3'd2,
        S_WALK    = 3'd3,
        S_DONE    = 3'd4
    } res_state_e;

    function automatic logic mode_supported(input logic [2:0] m);
        return (m == MODE_FIXED) || (m == MODE_LOWEST) || (m == MODE_NMI);
    endfunction

endpackage

// File: rtl/irq_dest_match.sv
module irq_dest_match #(
    parameter int NCPU = 16,
    parameter int ID_W = 8
) (
    input  logic [ID_W-1:0]      dest,
    input  logic                 logical,
    input  logic [NCPU-1:0]      present,
    input  logic [NCPU*ID_W-1:0] phys_ids,
    input  logic [NCPU*ID_W-1:0] logic_ids,
    output logic [NCPU-1:0]      target_mask
);
    localparam logic [ID_W-1:0] BCAST_ID = {ID_W{1'b1}};

    logic [NCPU-1:0] phys_hit;
    logic [NCPU-1:0] logic_hit;
    logic [NCPU-1:0] phys_first;

    for (genvar g = 0; g < NCPU; g++) begin : g_cmp
        assign phys_hit[g]  = present[g] && (phys_ids[g*ID_W +: ID_W] == dest);
        assign logic_hit[g] = present[g] && ((logic_ids[g*ID_W +: ID_W] & dest) != '0);
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        phys_first = '0;
        for (int i = 0; i < NCPU; i++) begin
            if (phys_hit[i] && !found) begin
                phys_first[i] = 1'b1;
                found         = 1'b1;
            end
        end
    end

    always_comb begin
        if (!logical) begin
            target_mask = (dest == BCAST_ID) ? present : phys_first;
        end else if (dest == '0) begin
            target_mask = '0;
        end else begin
            target_mask = logic_hit;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NCPU   = 16,
    parameter int PRIO_W = 4
) (
    input  logic [NCPU-1:0]        cand,
    input  logic [NCPU*PRIO_W-1:0] prio,
    output logic [NCPU-1:0]        winner
);
    always_comb begin
        logic              have;
        logic [PRIO_W-1:0] best;
        have   = 1'b0;
        best   = '0;
        winner = '0;
        for (int i = 0; i < NCPU; i++) begin
            if (cand[i] && (!have || (prio[i*PRIO_W +: PRIO_W] < best))) begin
                have   = 1'b1;
                best   = prio[i*PRIO_W +: PRIO_W];
                winner = '0;
                winner[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_lsb_isolate.sv
module irq_lsb_isolate #(
    parameter int W = 16
) (
    input  logic [W-1:0] vec_in,
    output logic [W-1:0] lowest,
    output logic [W-1:0] rest
);
    assign lowest = vec_in & (~vec_in + W'(1));
    assign rest   = vec_in & ~lowest;
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
    import irq_res_pkg::*;
#(
    parameter int NCPU   = 16,
    parameter int ID_W   = 8,
    parameter int PRIO_W = 4,
    parameter int VEC_W  = 8,
    parameter int PIN_W  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [PIN_W-1:0]       req_pin,
    input  logic [VEC_W-1:0]       req_vector,
    input  logic [ID_W-1:0]        req_dest,
    input  logic                   req_logical,
    input  logic [2:0]             req_mode,
    input  logic                   req_level,
    input  logic [NCPU-1:0]        cpu_present,
    input  logic [NCPU*ID_W-1:0]   cpu_phys_id,
    input  logic [NCPU*ID_W-1:0]   cpu_logic_id,
    input  logic [NCPU*PRIO_W-1:0] cpu_prio,
    output logic [NCPU-1:0]        irq_strobe,
    output logic [VEC_W-1:0]       irq_vector,
    output logic                   irq_level,
    output logic [NCPU-1:0]        nmi_strobe,
    output logic                   done_valid,
    output logic                   done_delivered
);
    localparam logic [NCPU-1:0] CPU0_ONLY = NCPU'(1);

    res_state_e state_q, state_d;

    logic [PIN_W-1:0] pin_q;
    logic [VEC_W-1:0] vec_q;
    logic [ID_W-1:0]  dest_q;
    logic             logical_q;
    logic [2:0]       mode_q;
    logic             level_q;
    logic [NCPU-1:0]  mask_q;
    logic             delivered_q;

    logic [NCPU-1:0]  match_mask;
    logic [NCPU-1:0]  pick_mask;
    logic [NCPU-1:0]  walk_low;
    logic [NCPU-1:0]  walk_rest;
    logic             pin_zero;
    logic             accept;

    assign pin_zero = (pin_q == '0);
    assign accept   = (state_q == S_IDLE) && req_valid;

    irq_dest_match #(.NCPU(NCPU), .ID_W(ID_W)) u_match (
        .dest        (dest_q),
        .logical     (logical_q),
        .present     (cpu_present),
        .phys_ids    (cpu_phys_id),
        .logic_ids   (cpu_logic_id),
        .target_mask (match_mask)
    );

    irq_prio_pick #(.NCPU(NCPU), .PRIO_W(PRIO_W)) u_pick (
        .cand   (mask_q),
        .prio   (cpu_prio),
        .winner (pick_mask)
    );

    irq_lsb_isolate #(.W(NCPU)) u_lsb (
        .vec_in (mask_q),
        .lowest (walk_low),
        .rest   (walk_rest)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_valid) state_d = S_RESOLVE;
            S_RESOLVE: begin
                if ((match_mask == '0) || !mode_supported(mode_q))
                    state_d = S_DONE;
                else if (mode_q == MODE_LOWEST)
                    state_d = S_PICK;
                else
                    state_d = S_WALK;
            end
            S_PICK:    state_d = S_WALK;
            S_WALK:    if (walk_rest == '0) state_d = S_DONE;
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // request capture and target mask datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q       <= '0;
            vec_q       <= '0;
            dest_q      <= '0;
            logical_q   <= 1'b0;
            mode_q      <= MODE_FIXED;
            level_q     <= 1'b0;
            mask_q      <= '0;
            delivered_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        pin_q       <= req_pin;
                        vec_q       <= req_vector;
                        dest_q      <= req_dest;
                        logical_q   <= req_logical;
                        mode_q      <= req_mode;
                        level_q     <= req_level;
                        delivered_q <= 1'b0;
                    end
                end
                S_RESOLVE: begin
                    if (!mode_supported(mode_q) || (match_mask == '0))
                        mask_q <= '0;
                    else if ((mode_q == MODE_FIXED) && pin_zero)
                        mask_q <= CPU0_ONLY;
                    else
                        mask_q <= match_mask;
                end
                S_PICK: begin
                    mask_q <= pin_zero ? CPU0_ONLY : pick_mask;
                end
                S_WALK: begin
                    mask_q      <= walk_rest;
                    delivered_q <= 1'b1;
                end
                S_DONE: mask_q <= '0;
                default: mask_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready      = 1'b0;
        irq_strobe     = '0;
        nmi_strobe     = '0;
        irq_vector     = '0;
        irq_level      = 1'b0;
        done_valid     = 1'b0;
        done_delivered = 1'b0;
        unique case (state_q)
            S_IDLE:    req_ready = 1'b1;
            S_RESOLVE: ;
            S_PICK:    ;
            S_WALK: begin
                if (mode_q == MODE_NMI) begin
                    nmi_strobe = walk_low;
                end else begin
                    irq_strobe = walk_low;
                    irq_vector = vec_q;
                    irq_level  = level_q;
                end
            end
            S_DONE: begin
                done_valid     = 1'b1;
                done_delivered = delivered_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_dest_resolver_chk.sv
module irq_dest_resolver_chk #(
    parameter int NCPU = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [NCPU-1:0] irq_strobe,
    input logic [NCPU-1:0] nmi_strobe,
    input logic            done_valid,
    input logic            done_delivered
);
    AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_strobe)); // R6
    AST_NMI_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(nmi_strobe)); // R7
    AST_NMI_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_strobe != '0) |-> (irq_strobe == '0)); // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_strobe != '0) || (nmi_strobe != '0) || done_valid) |-> !req_ready); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid); // R11
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !done_valid)); // R11
    AST_DONE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> req_ready); // R11
    AST_DELIVERED_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_strobe != '0) || (nmi_strobe != '0)) |=>
            (((irq_strobe != '0) || (nmi_strobe != '0)) || (done_valid && done_delivered))); // R11
endmodule

bind irq_dest_resolver irq_dest_resolver_chk #(.NCPU(NCPU)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .irq_strobe     (irq_strobe),
    .nmi_strobe     (nmi_strobe),
    .done_valid     (done_valid),
    .done_delivered (done_delivered)
);

// File: tb/tb_irq_dest_resolver.sv
module tb_irq_dest_resolver;
    localparam int NCPU   = 6;
    localparam int ID_W   = 8;
    localparam int PRIO_W = 4;
    localparam int VEC_W  = 8;
    localparam int PIN_W  = 5;

    typedef struct {
        int              kind;      // 0 irq, 1 nmi, 2 done
        logic [NCPU-1:0] onehot;
        logic [VEC_W-1:0] vec;
        logic            lvl;
        logic            delivered;
        string           tag;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [PIN_W-1:0] req_pin = '0;
    logic [VEC_W-1:0] req_vector = '0;
    logic [ID_W-1:0]  req_dest = '0;
    logic             req_logical = 1'b0;
    logic [2:0]       req_mode = '0;
    logic             req_level = 1'b0;
    logic [NCPU-1:0]  cpu_present;
    logic [NCPU*ID_W-1:0]   cpu_phys_id;
    logic [NCPU*ID_W-1:0]   cpu_logic_id;
    logic [NCPU*PRIO_W-1:0] cpu_prio;
    logic [NCPU-1:0]  irq_strobe;
    logic [VEC_W-1:0] irq_vector;
    logic             irq_level;
    logic [NCPU-1:0]  nmi_strobe;
    logic             done_valid;
    logic             done_delivered;

    int checks = 0;
    int fails = 0;
    int done_cnt = 0;
    bit finished = 0;
    exp_item_t sb[$];

    always #10 clk = ~clk;

    irq_dest_resolver #(.NCPU(NCPU), .ID_W(ID_W), .PRIO_W(PRIO_W),
                        .VEC_W(VEC_W), .PIN_W(PIN_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_pin(req_pin), .req_vector(req_vector), .req_dest(req_dest),
        .req_logical(req_logical), .req_mode(req_mode), .req_level(req_level),
        .cpu_present(cpu_present), .cpu_phys_id(cpu_phys_id),
        .cpu_logic_id(cpu_logic_id), .cpu_prio(cpu_prio),
        .irq_strobe(irq_strobe), .irq_vector(irq_vector), .irq_level(irq_level),
        .nmi_strobe(nmi_strobe), .done_valid(done_valid), .done_delivered(done_delivered)
    );

    logic [ID_W-1:0]   phys_tab [NCPU] = '{8'h10, 8'h11, 8'h12, 8'h12, 8'h14, 8'h15};
    logic [ID_W-1:0]   log_tab  [NCPU] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h03, 8'h06};
    logic [PRIO_W-1:0] prio_tab [NCPU] = '{4'd5, 4'd3, 4'd3, 4'd7, 4'd0, 4'd9};

    initial begin
        cpu_present = 6'b101111;
        for (int i = 0; i < NCPU; i++) begin
            cpu_phys_id[i*ID_W +: ID_W]    = phys_tab[i];
            cpu_logic_id[i*ID_W +: ID_W]   = log_tab[i];
            cpu_prio[i*PRIO_W +: PRIO_W]   = prio_tab[i];
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reference target mask from the requirements (R2, R3, R4)
    function automatic logic [NCPU-1:0] ref_mask(input logic [ID_W-1:0] d, input logic lg);
        logic [NCPU-1:0] m = '0;
        if (!lg) begin
            if (d == 8'hFF) return cpu_present;
            for (int i = 0; i < NCPU; i++)
                if (cpu_present[i] && phys_tab[i] == d) begin
                    m[i] = 1'b1;
                    return m;
                end
            return m;
        end
        if (d == '0) return m;
        for (int i = 0; i < NCPU; i++)
            if (cpu_present[i] && ((log_tab[i] & d) != '0)) m[i] = 1'b1;
        return m;
    endfunction

    task automatic push(input int kind, input logic [NCPU-1:0] oh, input logic [VEC_W-1:0] v,
                        input logic lv, input logic dl, input string tag);
        exp_item_t it;
        it.kind = kind; it.onehot = oh; it.vec = v; it.lvl = lv;
        it.delivered = dl; it.tag = tag;
        sb.push_back(it);
    endtask

    // Driver: computes expected items, pushes them, then presents the request
    task automatic send(input logic [PIN_W-1:0] pin, input logic [VEC_W-1:0] vec,
                        input logic [ID_W-1:0] dest, input logic lg, input logic [2:0] mode,
                        input logic lvl, input int hold, input string tag);
        logic [NCPU-1:0] m;
        logic [NCPU-1:0] oh;
        int prev;
        int best;
        m = ref_mask(dest, lg);
        if (m == '0 || !(mode == 3'b000 || mode == 3'b001 || mode == 3'b100)) begin
            push(2, '0, '0, 1'b0, 1'b0, tag);               // R5 R10
        end else if (mode == 3'b001) begin
            best = -1;
            for (int i = 0; i < NCPU; i++)
                if (m[i] && (best < 0 || prio_tab[i] < prio_tab[best])) best = i;
            if (pin == '0) best = 0;                         // R9
            oh = '0; oh[best] = 1'b1;
            push(0, oh, vec, lvl, 1'b0, tag);                // R8
            push(2, '0, '0, 1'b0, 1'b1, tag);
        end else begin
            if (mode == 3'b000 && pin == '0) m = NCPU'(1);   // R9
            for (int i = 0; i < NCPU; i++)
                if (m[i]) begin
                    oh = '0; oh[i] = 1'b1;
                    push(mode == 3'b100 ? 1 : 0, oh, vec, lvl, 1'b0, tag); // R6 R7
                end
            push(2, '0, '0, 1'b0, 1'b1, tag);
        end
        prev = done_cnt;
        @(negedge clk);
        req_pin = pin; req_vector = vec; req_dest = dest;
        req_logical = lg; req_mode = mode; req_level = lvl; req_valid = 1'b1;
        @(negedge clk);
        for (int h = 0; h < hold; h++) begin                 // R11: ignored while busy
            req_vector = vec ^ 8'hFF; req_dest = 8'hFF; req_logical = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        wait (done_cnt == prev + 1);
        @(negedge clk);
        check(sb.size() == 0, tag, "items left in scoreboard", sb.size(), 0);
        check(req_ready == 1'b1, "R11", "ready after retire", req_ready, 1);
    endtask

    // Monitor: pops expected items as outputs appear
    always @(negedge clk) begin
        if (rst_n && !finished && ((irq_strobe != '0) || (nmi_strobe != '0) || done_valid)) begin
            if (sb.size() == 0) begin
                check(1'b0, "R11", "unexpected output", {irq_strobe, nmi_strobe}, 0);
            end else begin
                exp_item_t e;
                e = sb.pop_front();
                if (e.kind == 2) begin
                    check(done_valid && irq_strobe == '0 && nmi_strobe == '0, e.tag,
                          "completion expected", {irq_strobe, nmi_strobe, done_valid}, 1);
                    check(done_delivered == e.delivered, e.tag, "delivered flag",
                          done_delivered, e.delivered);
                    done_cnt++;
                end else if (e.kind == 1) begin
                    check(nmi_strobe == e.onehot && irq_strobe == '0 && !done_valid, e.tag,
                          "nmi strobe", {irq_strobe, nmi_strobe}, e.onehot);
                end else begin
                    check(irq_strobe == e.onehot && nmi_strobe == '0 && !done_valid, e.tag,
                          "irq strobe", {nmi_strobe, irq_strobe}, e.onehot);
                    check(irq_vector == e.vec && irq_level == e.lvl, e.tag, "vector/level",
                          {irq_level, irq_vector}, {e.lvl, e.vec});
                end
                check(!req_ready, "R11", "ready low while busy", req_ready, 0);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(irq_strobe == '0 && nmi_strobe == '0, "R1", "strobes after reset",
              {irq_strobe, nmi_strobe}, 0);
        check(done_valid == 1'b0, "R1", "done after reset", done_valid, 0);

        send(5'd3, 8'h41, 8'hFF, 1'b0, 3'b000, 1'b1, 0, "R2");  // broadcast 0,1,2,3,5
        send(5'd2, 8'h42, 8'h12, 1'b0, 3'b000, 1'b0, 0, "R3");  // first match only cpu2
        send(5'd2, 8'h43, 8'h14, 1'b0, 3'b000, 1'b0, 0, "R5");  // matches absent cpu
        send(5'd2, 8'h44, 8'h00, 1'b1, 3'b000, 1'b0, 0, "R4");  // logical zero
        send(5'd7, 8'h45, 8'h06, 1'b1, 3'b000, 1'b1, 0, "R4");  // cpus 1,2,5
        send(5'd7, 8'h46, 8'h0F, 1'b1, 3'b100, 1'b0, 0, "R7");  // nmi 0,1,2,3,5
        send(5'd5, 8'h47, 8'h06, 1'b1, 3'b001, 1'b0, 0, "R8");  // tie -> cpu1
        send(5'd5, 8'h48, 8'h0C, 1'b1, 3'b001, 1'b1, 0, "R8");  // min -> cpu2
        send(5'd0, 8'h49, 8'h06, 1'b1, 3'b001, 1'b0, 0, "R9");  // pin0 lowest -> cpu0
        send(5'd0, 8'h4A, 8'hFF, 1'b0, 3'b000, 1'b0, 0, "R9");  // pin0 fixed -> cpu0
        send(5'd4, 8'h4B, 8'hFF, 1'b0, 3'b010, 1'b0, 0, "R10"); // unsupported
        send(5'd4, 8'h4C, 8'hFF, 1'b0, 3'b111, 1'b0, 0, "R10"); // unsupported
        send(5'd6, 8'h4D, 8'hFF, 1'b0, 3'b000, 1'b0, 3, "R11"); // held request ignored
        send(5'd6, 8'h4E, 8'h11, 1'b0, 3'b100, 1'b1, 0, "R7");  // nmi single cpu1

        repeat (4) @(negedge clk);
        check(sb.size() == 0 && irq_strobe == '0 && nmi_strobe == '0, "R11",
              "quiet at end", sb.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL R11 watchdog expired actual=%0d expected=%0d", done_cnt, 14);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule